// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Sequencer

This block loads a configuration bitstream into an FPGA that is set up for slave serial loading. A processor drives it through three registers. It writes a 2-bit request code to choose the next phase, writes bitstream bytes into a data register, and polls a 4-bit status code. On the FPGA side the block drives the active-low program line, the configuration clock and the serial data line. It watches the active-low, open-drain init line and the done line, both through two-flop synchronizers.

A start request does three things in turn. It holds the program line low for longer than the minimum pulse, then waits until the target shows init and done both low. After that it waits for init to be released and lets a settling interval pass before it reports that initialisation is complete. In the data phase, each accepted byte goes out MSB first, one bit per configuration clock. Every clock phase meets its minimum high and low times. The clock simply stays low between bytes while the host is slow. A finish request issues trailing clocks until done rises. Init falling during the data or finish phase is treated as a configuration error: clocking stops until the host restarts.

All minimum times are given in nanoseconds and converted, rounding up, into cycle counts of the system clock. The system clock frequency is a parameter.

Top module: `sercfg_top`

## Requirements
- R1: After reset, cfg_prog_n is 1, cfg_cclk is 0, host_busy is 0 and host_status is 4'b0000.
- R2: A request write with code 2'b01 (host_sel=0, host_wdata[1:0]) is accepted in any state. It drives cfg_prog_n low for strictly more than PROG_NS (201 or more cycles at 100 MHz) and then releases it high.
- R3: host_status[1] (init complete) rises only after the synchronized init and done inputs have both been seen low, init has returned high, and at least POST_NS has elapsed (500 or more cycles at 100 MHz after init goes high).
- R4: A request with code 2'b10 moves the block into the data phase only while host_status[1] is 1. In the data phase host_status[0] (ready) is 1 exactly when no byte is being shifted, so the status reads 4'b0011 while idle in that phase.
- R5: A byte written with host_sel=1 in the data phase is shifted out MSB first, exactly one bit per cfg_cclk rising edge, 8 rising edges per byte. cfg_din is stable for at least SETUP_NS (5 cycles at 100 MHz) before each rising edge. host_busy is 1 while the byte is shifted.
- R6: Every cfg_cclk low phase and every high phase that is not cut short by an abort or error lasts at least HALF_NS (8 cycles at 100 MHz).
- R7: Data writes are ignored while host_busy is 1 and outside the data phase: they produce no cfg_cclk edge and do not change the bit stream.
- R8: While in the data or finish phase, cfg_init_n low puts the block into the error state. host_status reads 4'b0100 and cfg_cclk stays low. Requests 2'b10 and 2'b11 and data writes have no effect in this state; only 2'b01 or 2'b00 leaves it.
- R9: A request with code 2'b11 is accepted only in the data phase with host_busy at 0; otherwise it is ignored. Once accepted, the block issues trailing clock pulses until synchronized done is 1. It then reports host_status 4'b1010 and keeps cfg_cclk low.
- R10: A request with code 2'b00 aborts from any state. Afterwards host_status is 4'b0000, cfg_prog_n is 1, host_busy is 0 and cfg_cclk stays low.
- R11: host_status bits: [0] ready, [1] init complete, [2] error, [3] done. At most one of bits 3, 2 and 0 is 1. Bit 0 implies bit 1, and bit 2 excludes bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | 0 = request register, 1 = data register |
| host_wdata | input | BYTE_W | Write data; bits [1:0] carry the request code |
| host_status | output | 4 | Status code {done, error, init complete, ready} |
| host_busy | output | 1 | A byte or trailing pulse is being clocked out |
| cfg_prog_n | output | 1 | Active-low program line to the target |
| cfg_init_n | input | 1 | Active-low init/status line from the target (open-drain, pulled up on the board) |
| cfg_done | input | 1 | Done line from the target |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_din | output | 1 | Serial configuration data |

## Verification
The bench builds the block with its defaults: CLK_MHZ=100, PROG_NS=2000, POST_NS=5000, HALF_NS=80, SETUP_NS=50, BYTE_W=8. These give a 202-cycle program pulse, a 500-cycle settling wait and 8-cycle clock phases, so several complete start, load, finish, error and abort sequences fit in a few thousand cycles. A behavioural target model answers the program pulse with init and done, raises done after a chosen number of trailing clocks, and can pull init low in the middle of a byte. Every clock the bench checks clock phase widths, data setup, the expected bit queue and the quiet-clock windows.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WLOW,
    ST_WHIGH,
    ST_SETTLE,
    ST_ARMED,
    ST_DATA,
    ST_FLUSH,
    ST_DONE,
    ST_FAULT
  } seq_state_t;

  localparam logic [1:0] REQ_ABORT  = 2'b00;
  localparam logic [1:0] REQ_START  = 2'b01;
  localparam logic [1:0] REQ_DATA   = 2'b10;
  localparam logic [1:0] REQ_FINISH = 2'b11;

  localparam int STAT_READY = 0;
  localparam int STAT_INIT  = 1;
  localparam int STAT_ERR   = 2;
  localparam int STAT_DONE  = 3;

  function automatic int ns_to_cyc_ceil(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/sercfg_timer.sv
module sercfg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/sercfg_shift.sv
module sercfg_shift #(
  parameter int BYTE_W   = 8,
  parameter int HALF_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kill,
  input  logic              load,
  input  logic              flush_go,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              cclk,
  output logic              din,
  output logic              busy
);
  localparam int CNT_W = $clog2(HALF_CYC + 1);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] PH_RELOAD = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0]  ph_cnt;
  logic [BIT_W-1:0]  bits_left;
  logic [BYTE_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cclk      <= 1'b0;
      din       <= 1'b0;
      busy      <= 1'b0;
      ph_cnt    <= '0;
      bits_left <= '0;
      sreg      <= '0;
    end else if (kill) begin
      cclk      <= 1'b0;
      busy      <= 1'b0;
      ph_cnt    <= '0;
      bits_left <= '0;
    end else if (!busy) begin
      if (load) begin
        sreg      <= byte_in;
        din       <= byte_in[BYTE_W-1];
        bits_left <= BIT_W'(BYTE_W);
        busy      <= 1'b1;
        cclk      <= 1'b0;
        ph_cnt    <= PH_RELOAD;
      end else if (flush_go) begin
        sreg      <= '1;
        din       <= 1'b1;
        bits_left <= BIT_W'(1);
        busy      <= 1'b1;
        cclk      <= 1'b0;
        ph_cnt    <= PH_RELOAD;
      end
    end else if (ph_cnt != '0) begin
      ph_cnt <= ph_cnt - 1'b1;
    end else if (!cclk) begin
      cclk   <= 1'b1;
      ph_cnt <= PH_RELOAD;
    end else begin
      cclk      <= 1'b0;
      bits_left <= bits_left - 1'b1;
      if (bits_left == BIT_W'(1)) begin
        busy <= 1'b0;
      end else begin
        sreg   <= {sreg[BYTE_W-2:0], 1'b0};
        din    <= sreg[BYTE_W-2];
        ph_cnt <= PH_RELOAD;
      end
    end
  end
endmodule

// File: rtl/sercfg_top.sv
module sercfg_top
  import sercfg_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int PROG_NS  = 2000,
  parameter int POST_NS  = 5000,
  parameter int HALF_NS  = 80,
  parameter int SETUP_NS = 50,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [3:0]        host_status,
  output logic              host_busy,
  output logic              cfg_prog_n,
  input  logic              cfg_init_n,
  input  logic              cfg_done,
  output logic              cfg_cclk,
  output logic              cfg_din
);
  // strictly longer than the pulse minimum
  localparam int PROG_CYC = (PROG_NS * CLK_MHZ) / 1000 + 1;
  localparam int POST_CYC = ns_to_cyc_ceil(POST_NS, CLK_MHZ);
  localparam int HI_CYC   = ns_to_cyc_ceil(HALF_NS, CLK_MHZ);
  localparam int SU_CYC   = ns_to_cyc_ceil(SETUP_NS, CLK_MHZ);
  localparam int HS_CYC   = (HI_CYC > SU_CYC) ? HI_CYC : SU_CYC;
  localparam int HALF_CYC = (HS_CYC < 1) ? 1 : HS_CYC;
  localparam int TMAX     = (PROG_CYC > POST_CYC) ? PROG_CYC : POST_CYC;
  localparam int TMR_W    = $clog2(TMAX + 1);

  seq_state_t state, nxt;
  logic       init_s, done_s;
  logic       tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic       shf_busy, shf_kill, shf_load, shf_flush;
  logic       req_wr;
  logic [1:0] req_code;
  logic       prog_n_q;

  sercfg_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cfg_init_n, cfg_done}),
    .q   ({init_s, done_s})
  );

  sercfg_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  assign req_wr   = host_wr && !host_sel;
  assign req_code = host_wdata[1:0];

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(PROG_CYC);
    if (req_wr) begin
      case (req_code)
        REQ_ABORT: nxt = ST_IDLE;
        REQ_START: begin
          nxt      = ST_PULSE;
          tmr_load = 1'b1;
        end
        REQ_DATA: begin
          if (state == ST_ARMED) nxt = ST_DATA;
        end
        default: begin
          if (state == ST_DATA && !shf_busy) nxt = ST_FLUSH;
        end
      endcase
    end else begin
      case (state)
        ST_PULSE:  if (tmr_zero) nxt = ST_WLOW;
        ST_WLOW:   if (!init_s && !done_s) nxt = ST_WHIGH;
        ST_WHIGH: begin
          if (init_s) begin
            nxt      = ST_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(POST_CYC);
          end
        end
        ST_SETTLE: if (tmr_zero) nxt = ST_ARMED;
        ST_ARMED:  if (!init_s) nxt = ST_FAULT;
        ST_DATA:   if (!init_s) nxt = ST_FAULT;
        ST_FLUSH: begin
          if (!init_s)                  nxt = ST_FAULT;
          else if (done_s && !shf_busy) nxt = ST_DONE;
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      prog_n_q <= 1'b1;
    end else begin
      state    <= nxt;
      prog_n_q <= (nxt != ST_PULSE);
    end
  end

  assign shf_kill  = (state != ST_DATA) && (state != ST_FLUSH);
  assign shf_load  = host_wr && host_sel && (state == ST_DATA) && !shf_busy;
  assign shf_flush = (state == ST_FLUSH) && !done_s;

  sercfg_shift #(.BYTE_W(BYTE_W), .HALF_CYC(HALF_CYC)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .kill     (shf_kill),
    .load     (shf_load),
    .flush_go (shf_flush),
    .byte_in  (host_wdata),
    .cclk     (cfg_cclk),
    .din      (cfg_din),
    .busy     (shf_busy)
  );

  always_comb begin
    host_status = 4'b0000;
    host_status[STAT_READY] = (state == ST_DATA) && !shf_busy;
    host_status[STAT_INIT]  = (state == ST_ARMED) || (state == ST_DATA) ||
                              (state == ST_FLUSH) || (state == ST_DONE);
    host_status[STAT_ERR]   = (state == ST_FAULT);
    host_status[STAT_DONE]  = (state == ST_DONE);
  end

  assign host_busy  = shf_busy;
  assign cfg_prog_n = prog_n_q;
endmodule

// File: rtl/sercfg_chk.sv
module sercfg_chk #(
  parameter int PROG_CYC = 201,
  parameter int HALF_CYC = 8
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] status,
  input logic       busy,
  input logic       prog_n,
  input logic       cclk
);
  int plow_cnt;
  int lo_cnt;
  int hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      plow_cnt <= 0;
      lo_cnt   <= 0;
      hi_cnt   <= 0;
    end else begin
      plow_cnt <= prog_n ? 0 : plow_cnt + 1;
      if (cclk) begin
        hi_cnt <= hi_cnt + 1;
        lo_cnt <= 0;
      end else begin
        lo_cnt <= lo_cnt + 1;
        hi_cnt <= 0;
      end
    end
  end

  assert_rst_values_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (prog_n && !cclk && !busy && status == 4'b0000));

  assert_prog_width_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_n) |-> (plow_cnt >= PROG_CYC));

  assert_ready_idle_R4: assert property (@(posedge clk) disable iff (rst)
    status[0] |-> !busy);

  assert_cclk_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk) |-> (lo_cnt >= HALF_CYC));

  assert_cclk_high_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(cclk) && status[1]) |-> (hi_cnt >= HALF_CYC));

  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (status[2] && $past(status[2]) && $past(status[2], 2)) |-> !cclk);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    status[3] |-> (!cclk && !busy));

  assert_status_code_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({status[3], status[2], status[0]}) &&
    !(status[2] && status[1]) && (!status[0] || status[1]));
endmodule

bind sercfg_top sercfg_chk #(.PROG_CYC(PROG_CYC), .HALF_CYC(HALF_CYC)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .status (host_status),
  .busy   (host_busy),
  .prog_n (cfg_prog_n),
  .cclk   (cfg_cclk)
);

// File: tb/sercfg_top_tb_top.sv
`timescale 1ns/1ps
module sercfg_top_tb_top;
  // expected minima at 100 MHz, derived from the requirements
  localparam int PROG_MIN  = 201; // > 2000 ns at 10 ns per cycle
  localparam int POST_MIN  = 500; // >= 5000 ns
  localparam int H_MIN     = 8;   // >= 80 ns
  localparam int SU_MIN    = 5;   // >= 50 ns
  localparam int INIT_HOLD = 30;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0;
  logic       host_sel = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [3:0] host_status;
  logic       host_busy;
  logic       cfg_prog_n;
  logic       cfg_cclk;
  logic       cfg_din;
  logic       tgt_init = 1'b1;
  logic       tgt_done = 1'b0;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  ended = 1'b0;
  bit  inject_err = 1'b0;
  bit  forbid_clk = 1'b0;
  bit  kill_window = 1'b0;
  int  done_at = -1;
  int  tgt_rises = 0;
  int  rise_count = 0;
  bit  expq[$];

  always #5 clk = ~clk;

  sercfg_top dut_i (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_sel    (host_sel),
    .host_wdata  (host_wdata),
    .host_status (host_status),
    .host_busy   (host_busy),
    .cfg_prog_n  (cfg_prog_n),
    .cfg_init_n  (tgt_init),
    .cfg_done    (tgt_done),
    .cfg_cclk    (cfg_cclk),
    .cfg_din     (cfg_din)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // behavioural target FPGA
  initial begin
    bit prev_c = 1'b0;
    int hold = 0;
    forever begin
      @(negedge clk);
      #1;
      if (!cfg_prog_n) begin
        tgt_init = 1'b0;
        tgt_done = 1'b0;
        hold     = INIT_HOLD;
      end else if (hold > 0) begin
        hold--;
        if (hold == 0) tgt_init = 1'b1;
      end
      if (inject_err) tgt_init = 1'b0;
      if (cfg_cclk && !prev_c) tgt_rises++;
      prev_c = cfg_cclk;
      if (done_at >= 0 && tgt_rises >= done_at) tgt_done = 1'b1;
    end
  end

  // per-clock monitor
  initial begin
    bit pc = 1'b0;
    bit pd = 1'b0;
    int plen = 0;
    int dage = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (cfg_cclk != pc) begin
          if (cfg_cclk) begin
            chk(plen >= H_MIN, "R6 low phase width", plen, H_MIN);
            chk(dage >= SU_MIN, "R5 din setup", dage, SU_MIN);
            if (expq.size() > 0) begin
              bit e;
              e = expq.pop_front();
              chk(cfg_din == e, "R5 din bit", cfg_din, e);
            end
            rise_count++;
          end else if (!kill_window) begin
            chk(plen >= H_MIN, "R6 high phase width", plen, H_MIN);
          end
          plen = 1;
        end else begin
          plen++;
        end
        if (cfg_din != pd) dage = 1; else dage++;
        if (forbid_clk) chk(cfg_cclk == 1'b0, "R8 R9 R10 clock quiet", cfg_cclk, 0);
        pc = cfg_cclk;
        pd = cfg_din;
      end
    end
  end

  task automatic host_write(input bit sel, input logic [7:0] d);
    host_wr    = 1'b1;
    host_sel   = sel;
    host_wdata = d;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic do_start();
    int plow = 0;
    int since = -1;
    host_write(1'b0, 8'h01);
    while (!cfg_prog_n) begin
      plow++;
      @(negedge clk);
    end
    chk(plow >= PROG_MIN, "R2 program pulse length", plow, PROG_MIN);
    chk(cfg_prog_n == 1'b1, "R2 program released", cfg_prog_n, 1);
    while (!host_status[1]) begin
      if (since < 0 && tgt_init) since = 0;
      if (since >= 0) since++;
      @(negedge clk);
    end
    chk(since >= POST_MIN, "R3 settle after init", since, POST_MIN);
    chk(host_status == 4'b0010, "R3 R11 armed status", host_status, 2);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit try_finish);
    int r0;
    r0 = rise_count;
    for (int i = 7; i >= 0; i--) expq.push_back(b[i]);
    host_write(1'b1, b);
    chk(host_busy == 1'b1, "R5 busy while shifting", host_busy, 1);
    host_write(1'b1, ~b);
    if (try_finish) host_write(1'b0, 8'h03);
    while (host_busy) @(negedge clk);
    chk(expq.size() == 0, "R7 write during busy ignored", expq.size(), 0);
    chk(rise_count - r0 == 8, "R5 eight clocks per byte", rise_count - r0, 8);
    chk(host_status == 4'b0011, "R4 ready in data phase", host_status, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_prog_n == 1'b1, "R1 prog_n after reset", cfg_prog_n, 1);
    chk(cfg_cclk == 1'b0, "R1 cclk after reset", cfg_cclk, 0);
    chk(host_busy == 1'b0, "R1 busy after reset", host_busy, 0);
    chk(host_status == 4'b0000, "R1 status after reset", host_status, 0);

    // data request before start is ignored
    host_write(1'b0, 8'h02);
    chk(host_status == 4'b0000, "R4 data request before init", host_status, 0);

    do_start();

    // data and finish before data phase are ignored
    r0 = rise_count;
    host_write(1'b1, 8'h81);
    host_write(1'b0, 8'h03);
    repeat (40) @(negedge clk);
    chk(rise_count == r0, "R7 data outside data phase", rise_count - r0, 0);
    chk(host_status == 4'b0010, "R9 finish outside data phase", host_status, 2);

    host_write(1'b0, 8'h02);
    chk(host_status == 4'b0011, "R4 enter data phase", host_status, 3);

    send_byte(8'hA5, 1'b0);
    send_byte(8'h3C, 1'b0);
    repeat (37) @(negedge clk);
    send_byte(8'h01, 1'b0);
    send_byte(8'h80, 1'b1);  // finish while busy: R9 ignored
    repeat (3) @(negedge clk);
    send_byte(8'hFF, 1'b0);
    send_byte(8'h00, 1'b0);

    // finish: three trailing clocks then done
    r0 = rise_count;
    done_at = tgt_rises + 3;
    host_write(1'b0, 8'h03);
    while (!host_status[3]) @(negedge clk);
    done_at = -1;
    chk(host_status == 4'b1010, "R9 R11 done status", host_status, 10);
    chk(rise_count - r0 >= 3, "R9 trailing clocks", rise_count - r0, 3);
    r0 = rise_count;
    forbid_clk = 1'b1;
    repeat (50) @(negedge clk);
    forbid_clk = 1'b0;
    chk(rise_count == r0, "R9 no clocks after done", rise_count - r0, 0);

    // configuration error in the middle of a byte
    do_start();
    host_write(1'b0, 8'h02);
    for (int i = 7; i >= 0; i--) expq.push_back(1'(8'hC3 >> i));
    host_write(1'b1, 8'hC3);
    repeat (20) @(negedge clk);
    kill_window = 1'b1;
    inject_err  = 1'b1;
    repeat (8) @(negedge clk);
    chk(host_status == 4'b0100, "R8 error status", host_status, 4);
    expq.delete();
    r0 = rise_count;
    forbid_clk = 1'b1;
    host_write(1'b0, 8'h02);
    host_write(1'b1, 8'hFF);
    host_write(1'b0, 8'h03);
    repeat (30) @(negedge clk);
    chk(host_status == 4'b0100, "R8 requests ignored in error", host_status, 4);
    chk(rise_count == r0, "R8 clock stopped in error", rise_count - r0, 0);
    forbid_clk  = 1'b0;
    kill_window = 1'b0;
    inject_err  = 1'b0;
    do_start();
    chk(host_status == 4'b0010, "R8 restart clears error", host_status, 2);

    // abort in the middle of a byte
    host_write(1'b0, 8'h02);
    for (int i = 7; i >= 0; i--) expq.push_back(1'(8'h5A >> i));
    host_write(1'b1, 8'h5A);
    repeat (30) @(negedge clk);
    kill_window = 1'b1;
    host_write(1'b0, 8'h00);
    repeat (3) @(negedge clk);
    expq.delete();
    chk(host_status == 4'b0000, "R10 status after abort", host_status, 0);
    chk(cfg_prog_n == 1'b1, "R10 prog_n after abort", cfg_prog_n, 1);
    chk(host_busy == 1'b0, "R10 busy after abort", host_busy, 0);
    r0 = rise_count;
    forbid_clk = 1'b1;
    repeat (30) @(negedge clk);
    forbid_clk  = 1'b0;
    kill_window = 1'b0;
    chk(rise_count == r0, "R10 clock quiet after abort", rise_count - r0, 0);

    finish_run();
  end
endmodule